// File: doc/BRIEF.md
# Two-Delta Stride Value Predictor

This block guesses the next result of register-writing instructions from the values each one produced before. A table is indexed by a slice of the instruction address. Each entry keeps the most recent result, a candidate stride, a committed stride and a small saturating confidence counter. The lookup port is combinational. Given an address, it returns the last value plus the committed stride, and it raises a confident flag when the counter is high enough for the pipeline to use the guess.

The update port carries the actual result of a retired instruction. First it judges the guess the entry would have made before training, and moves the confidence counter up or down. In the same cycle it refreshes the value and the strides. The committed stride changes only when the same new difference has been seen twice in a row. A single glitch in a loop therefore does not break a trained stride. A constant sequence is simply a stride of zero. Instructions whose addresses share an index share an entry, and nothing detects this.

Top module: `stride_value_predictor`

## Requirements
- R1: After reset every entry is invalid. A lookup of an invalid entry returns a predicted value of 0 with the confident flag low.
- R2: Address bits [7:2] select one of 64 entries. All other address bits are ignored, so addresses that differ only outside [7:2] read and train the same entry.
- R3: An update to an invalid entry stores the value as the last value, sets both strides and the counter to 0, and marks the entry valid.
- R4: The predicted value of a valid entry is its last value plus its committed stride, modulo 2^32. It is available in the same cycle the address is applied.
- R5: Every update to a valid entry loads the candidate stride with the new value minus the stored last value, and stores the new value as the last value.
- R6: The committed stride takes the new difference only when that difference equals the candidate stride already stored. Otherwise the committed stride is unchanged.
- R7: On an update to a valid entry, the new value is compared with the pre-update prediction. The 2-bit counter increments on a match, saturating at 3, and decrements on a mismatch, saturating at 0.
- R8: The confident flag is high exactly when the entry is valid and its counter is 2 or 3.
- R9: When a lookup and an update hit the same index in one cycle, the lookup shows the pre-update contents. The update is visible to lookups from the cycle after the clock edge.
- R10: A repeated constant value is predicted as stride 0 and becomes confident after three updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_addr_i | input | 32 | Lookup instruction address |
| lk_pred_o | output | 32 | Predicted value for lk_addr_i |
| lk_conf_o | output | 1 | Prediction is confident |
| up_valid_i | input | 1 | Update strobe |
| up_addr_i | input | 32 | Instruction address of the update |
| up_value_i | input | 32 | Actual result used for training |

## Verification
The lookup results respond to lk_addr_i with zero cycles of latency. The bench therefore changes addresses on the falling edge and compares lk_pred_o and lk_conf_o one time unit later, inside the same low phase. An update takes effect on the rising edge that samples it. Each training check is made in the low phase after that edge, once up_valid_i has been dropped. The same-cycle case is sampled twice: before the edge, when the old contents must still show, and after it, when the trained contents must show.

// File: rtl/svp_pkg.sv
package svp_pkg;
  localparam int unsigned VAL_W = 32;
  localparam int unsigned CNT_W = 2;

  typedef struct packed {
    logic             vld;
    logic [CNT_W-1:0] cnt;
    logic [VAL_W-1:0] last;
    logic [VAL_W-1:0] s1;   // candidate stride
    logic [VAL_W-1:0] s2;   // committed stride
  } ent_t;
endpackage

// File: rtl/svp_table.sv
module svp_table #(
  parameter int unsigned IDX_W = 6,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    rd_a_idx_i,
  output svp_pkg::ent_t       rd_a_o,
  input  logic [IDX_W-1:0]    rd_b_idx_i,
  output svp_pkg::ent_t       rd_b_o,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  svp_pkg::ent_t       wr_ent_i
);
  svp_pkg::ent_t ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[g] <= '0;
      else if (we_i && wr_idx_i == IDX_W'(g)) ent_q[g] <= wr_ent_i;
    end
  end

  assign rd_a_o = ent_q[rd_a_idx_i];
  assign rd_b_o = ent_q[rd_b_idx_i];
endmodule

// File: rtl/svp_train.sv
module svp_train (
  input  svp_pkg::ent_t                cur_i,
  input  logic [svp_pkg::VAL_W-1:0]    value_i,
  output svp_pkg::ent_t                nxt_o
);
  import svp_pkg::*;
  logic [VAL_W-1:0] diff, guess;
  logic             hit;

  assign diff  = value_i - cur_i.last;
  assign guess = cur_i.last + cur_i.s2;
  assign hit   = (value_i == guess);

  always_comb begin
    nxt_o      = cur_i;
    nxt_o.last = value_i;
    if (!cur_i.vld) begin
      nxt_o.vld = 1'b1;
      nxt_o.cnt = '0;
      nxt_o.s1  = '0;
      nxt_o.s2  = '0;
    end else begin
      if (hit) begin
        if (cur_i.cnt != {CNT_W{1'b1}}) nxt_o.cnt = cur_i.cnt + 1'b1;
      end else begin
        if (cur_i.cnt != '0) nxt_o.cnt = cur_i.cnt - 1'b1;
      end
      nxt_o.s1 = diff;
      // commit only a stride seen twice running
      if (diff == cur_i.s1) nxt_o.s2 = diff;
    end
  end
endmodule

// File: rtl/svp_lookup.sv
module svp_lookup #(
  parameter int unsigned CONF_TH = 2
) (
  input  svp_pkg::ent_t             ent_i,
  output logic [svp_pkg::VAL_W-1:0] pred_o,
  output logic                      conf_o
);
  import svp_pkg::*;
  assign pred_o = ent_i.vld ? ent_i.last + ent_i.s2 : '0;
  assign conf_o = ent_i.vld && (ent_i.cnt >= CNT_W'(CONF_TH));
endmodule

// File: rtl/stride_value_predictor.sv
module stride_value_predictor #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned IDX_LSB = 2,
  parameter int unsigned CONF_TH = 2,
  localparam int unsigned VAL_W  = svp_pkg::VAL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic [VAL_W-1:0]  lk_pred_o,
  output logic              lk_conf_o,
  input  logic              up_valid_i,
  input  logic [ADDR_W-1:0] up_addr_i,
  input  logic [VAL_W-1:0]  up_value_i
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  svp_pkg::ent_t    lk_ent, up_ent, up_nxt;

  assign lk_idx = lk_addr_i[IDX_LSB +: IDX_W];
  assign up_idx = up_addr_i[IDX_LSB +: IDX_W];

  svp_table #(.IDX_W(IDX_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_a_idx_i (lk_idx),
    .rd_a_o     (lk_ent),
    .rd_b_idx_i (up_idx),
    .rd_b_o     (up_ent),
    .we_i       (up_valid_i),
    .wr_idx_i   (up_idx),
    .wr_ent_i   (up_nxt)
  );

  svp_train u_trn (
    .cur_i   (up_ent),
    .value_i (up_value_i),
    .nxt_o   (up_nxt)
  );

  svp_lookup #(.CONF_TH(CONF_TH)) u_lk (
    .ent_i  (lk_ent),
    .pred_o (lk_pred_o),
    .conf_o (lk_conf_o)
  );
endmodule

// File: rtl/svp_chk.sv
module svp_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned IDX_LSB = 2,
  parameter int unsigned CONF_TH = 2,
  localparam int unsigned DEPTH  = 1 << IDX_W
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [ADDR_W-1:0]         lk_addr_i,
  input logic [svp_pkg::VAL_W-1:0] lk_pred_o,
  input logic                      lk_conf_o,
  input logic                      up_valid_i,
  input logic [ADDR_W-1:0]         up_addr_i,
  input logic [svp_pkg::VAL_W-1:0] up_value_i,
  input svp_pkg::ent_t             mem_i [DEPTH]
);
  logic [IDX_W-1:0] li, ui;
  assign li = lk_addr_i[IDX_LSB +: IDX_W];
  assign ui = up_addr_i[IDX_LSB +: IDX_W];

  // R1
  inval_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_i[li].vld |-> (!lk_conf_o && lk_pred_o == '0));

  // R8
  conf_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_conf_o |-> (mem_i[li].vld && mem_i[li].cnt >= svp_pkg::CNT_W'(CONF_TH)));

  // R3
  first_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && !mem_i[ui].vld) |=>
      (mem_i[$past(ui)].vld && mem_i[$past(ui)].s2 == '0 &&
       mem_i[$past(ui)].last == $past(up_value_i)));

  // R7
  miss_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && mem_i[ui].vld && up_value_i != mem_i[ui].last + mem_i[ui].s2) |=>
      (mem_i[$past(ui)].cnt <= $past(mem_i[ui].cnt)));

  // R6
  s2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && mem_i[ui].vld && (up_value_i - mem_i[ui].last) != mem_i[ui].s1) |=>
      (mem_i[$past(ui)].s2 == $past(mem_i[ui].s2)));

  // R9
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_valid_i ##1 $stable(lk_addr_i)) |-> $stable(lk_pred_o));
endmodule

bind stride_value_predictor svp_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB), .CONF_TH(CONF_TH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lk_addr_i  (lk_addr_i),
  .lk_pred_o  (lk_pred_o),
  .lk_conf_o  (lk_conf_o),
  .up_valid_i (up_valid_i),
  .up_addr_i  (up_addr_i),
  .up_value_i (up_value_i),
  .mem_i      (u_tbl.ent_q)
);

// File: tb/sim_stride_value_predictor.sv
`timescale 1ns/1ps
module sim_stride_value_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [31:0] lk_pred;
  logic        lk_conf;
  logic        up_valid = 1'b0;
  logic [31:0] up_addr = '0;
  logic [31:0] up_value = '0;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  stride_value_predictor u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_addr_i(lk_addr), .lk_pred_o(lk_pred), .lk_conf_o(lk_conf),
    .up_valid_i(up_valid), .up_addr_i(up_addr), .up_value_i(up_value)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic look(string req, logic [31:0] a, logic [31:0] ep, logic ec);
    @(negedge clk);
    lk_addr = a;
    #1;
    chk(req, "pred", lk_pred, ep);
    chk(req, "conf", {31'd0, lk_conf}, {31'd0, ec});
  endtask

  task automatic upd(logic [31:0] a, logic [31:0] v);
    @(negedge clk);
    up_valid = 1'b1; up_addr = a; up_value = v;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic t_reset;
    look("R1", 32'h40, 32'd0, 1'b0);
    look("R1", 32'hFC, 32'd0, 1'b0);
  endtask

  // stride 10 at index 16, then a glitch and a new stride
  task automatic t_stride;
    upd(32'h40, 32'd10);
    look("R3", 32'h40, 32'd10, 1'b0);
    upd(32'h40, 32'd20);
    look("R6", 32'h40, 32'd20, 1'b0);   // S1 alone does not move prediction
    upd(32'h40, 32'd30);
    look("R5", 32'h40, 32'd40, 1'b0);   // counter floored at 0 by two misses (R7)
    upd(32'h40, 32'd40);
    upd(32'h40, 32'd50);
    look("R8", 32'h40, 32'd60, 1'b1);
    upd(32'h40, 32'd60);
    upd(32'h40, 32'd70);                // counter held at 3
    look("R4", 32'h40, 32'd80, 1'b1);
    upd(32'h40, 32'd71);
    look("R7", 32'h40, 32'd81, 1'b1);   // 3 -> 2, committed stride kept
    upd(32'h40, 32'd72);
    look("R6", 32'h40, 32'd73, 1'b0);   // new stride seen twice, 2 -> 1
  endtask

  task automatic t_alias;
    look("R2", 32'h43, 32'd73, 1'b0);
    look("R2", 32'h1_0140, 32'd73, 1'b0);
    look("R2", 32'h44, 32'd0, 1'b0);
  endtask

  task automatic t_constant;
    upd(32'h80, 32'd5);
    upd(32'h80, 32'd5);
    look("R10", 32'h80, 32'd5, 1'b0);
    upd(32'h80, 32'd5);
    look("R10", 32'h80, 32'd5, 1'b1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    lk_addr = 32'h80;
    up_valid = 1'b1; up_addr = 32'h80; up_value = 32'd9;
    #1;
    chk("R9", "pred before edge", lk_pred, 32'd5);
    chk("R9", "conf before edge", {31'd0, lk_conf}, 32'd1);
    @(negedge clk);
    up_valid = 1'b0;
    #1;
    chk("R9", "pred after edge", lk_pred, 32'd9);
    chk("R9", "conf after edge", {31'd0, lk_conf}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stride();
    t_alias();
    t_constant();
    t_same_cycle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule